// File: doc/BRIEF.md
# RV32M Multiply-Divide Execute Unit

This unit carries out the eight integer multiply and divide operations of the RV32M extension. It sits beside the base ALU and is fed by the same register-register control path: the decoder routes an instruction here when its opcode is 0110011 and its funct7 is 0000001. The 3-bit funct3 field is passed unchanged as the operation select. The unit takes two XLEN-bit operands and returns one XLEN-bit result.

The arithmetic is combinational. A parameterised chain of output registers follows it, and each register stage carries a valid bit alongside the result. With the default of one stage, the result appears one clock after the operands are accepted. A new operation can be issued on every cycle. Division by zero and the single signed-overflow case never trap. Each of them returns a fixed, defined value.

Top module: `mdu_exec`

## Requirements
- R1: With select 0 (MUL), the result is the low XLEN bits of the product of the two operands.
- R2: With select 1 (MULH), the result is the high XLEN bits of the product, with both operands treated as signed.
- R3: With select 2 (MULHSU), the result is the high XLEN bits of the product, with operand A treated as signed and operand B as unsigned.
- R4: With select 3 (MULHU), the result is the high XLEN bits of the product, with both operands treated as unsigned.
- R5: With select 4 (DIV), the result is the signed quotient A/B, truncated toward zero.
- R6: With select 5 (DIVU), the result is the unsigned quotient A/B.
- R7: With select 6 (REM), the result is the signed remainder. It is either zero or carries the sign of the dividend A.
- R8: With select 7 (REMU), the result is the unsigned remainder.
- R9: For DIV or DIVU with a divisor of zero, the result has all bits set.
- R10: For REM or REMU with a divisor of zero, the result equals the dividend A.
- R11: For DIV with A = 0x80000000 and B = 0xFFFFFFFF, the result is 0x80000000. For REM with the same operands, the result is 0.
- R12: out_valid reproduces in_valid exactly PIPE_STAGES clocks later, and the result of that operation appears in the same cycle. While rst_n is low, out_valid and out_result are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and select are valid this cycle |
| in_op | input | 3 | Operation select (funct3 encoding, 0 to 7) |
| in_a | input | XLEN | Operand A (rs1 value, dividend) |
| in_b | input | XLEN | Operand B (rs2 value, divisor) |
| out_valid | output | 1 | Result valid |
| out_result | output | XLEN | Operation result |

## Verification
The multiplies are tried with small positive values, with all-ones operands and with the most negative operand. These patterns separate the four signedness treatments: an all-ones operand yields a different high word under signed and under unsigned reading. Each divide is run with mixed-sign operand pairs, which tell truncation toward zero apart from floor division and confirm that the remainder follows the sign of the dividend. Zero divisors and the most-negative-by-minus-one pair cover the fixed results. Single valid pulses and back-to-back issue confirm the latency and that valid does not linger.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
   typedef enum logic [2:0] {
      OP_MUL    = 3'd0,
      OP_MULH   = 3'd1,
      OP_MULHSU = 3'd2,
      OP_MULHU  = 3'd3,
      OP_DIV    = 3'd4,
      OP_DIVU   = 3'd5,
      OP_REM    = 3'd6,
      OP_REMU   = 3'd7
   } mdu_op_e;
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul
   import mdu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  mdu_op_e          op,
   input  logic [XLEN-1:0]  a,
   input  logic [XLEN-1:0]  b,
   output logic [XLEN-1:0]  result
);
   localparam int PW = 2 * XLEN;

   logic          a_sgn, b_sgn;
   logic [PW-1:0] a_w, b_w, prod;

   // Sign-extend to double width; the product modulo 2^PW is then exact
   // for every signedness combination (R2, R3, R4).
   assign a_sgn = (op == OP_MULH) || (op == OP_MULHSU);
   assign b_sgn = (op == OP_MULH);
   assign a_w   = {{XLEN{a_sgn & a[XLEN-1]}}, a};
   assign b_w   = {{XLEN{b_sgn & b[XLEN-1]}}, b};
   assign prod  = a_w * b_w;

   // R1: low half for MUL, high half otherwise
   assign result = (op == OP_MUL) ? prod[XLEN-1:0] : prod[PW-1:XLEN];
endmodule

// File: rtl/mdu_div.sv
module mdu_div
   import mdu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  mdu_op_e          op,
   input  logic [XLEN-1:0]  a,
   input  logic [XLEN-1:0]  b,
   output logic [XLEN-1:0]  result
);
   logic            is_signed, want_rem, a_neg, b_neg, b_zero;
   logic [XLEN-1:0] a_mag, b_mag, q_mag, r_mag, q_fix, r_fix;

   assign is_signed = (op == OP_DIV) || (op == OP_REM);
   assign want_rem  = (op == OP_REM) || (op == OP_REMU);
   assign a_neg     = is_signed & a[XLEN-1];
   assign b_neg     = is_signed & b[XLEN-1];
   assign b_zero    = (b == '0);

   // Magnitude divide, then restore signs: truncation toward zero (R5),
   // remainder follows dividend (R7). The most-negative / -1 case falls
   // out naturally as quotient = A, remainder = 0 (R11).
   assign a_mag = a_neg ? (~a + 1'b1) : a;
   assign b_mag = b_neg ? (~b + 1'b1) : b;
   assign q_mag = b_zero ? '0 : (a_mag / b_mag);
   assign r_mag = b_zero ? '0 : (a_mag % b_mag);
   assign q_fix = (a_neg ^ b_neg) ? (~q_mag + 1'b1) : q_mag;
   assign r_fix = a_neg ? (~r_mag + 1'b1) : r_mag;

   always_comb begin
      if (b_zero) result = want_rem ? a : '1;   // R9, R10
      else        result = want_rem ? r_fix : q_fix;
   end
endmodule

// File: rtl/mdu_exec.sv
module mdu_exec
   import mdu_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int PIPE_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       in_op,
   input  logic [XLEN-1:0]  in_a,
   input  logic [XLEN-1:0]  in_b,
   output logic             out_valid,
   output logic [XLEN-1:0]  out_result
);
   initial begin
      assert (XLEN >= 2) else $error("mdu_exec: XLEN must be at least 2");
      assert (PIPE_STAGES >= 0 && PIPE_STAGES <= 8)
         else $error("mdu_exec: PIPE_STAGES must be 0..8");
   end

   mdu_op_e         op_e;
   logic [XLEN-1:0] mul_res, div_res, comb_res;

   assign op_e = mdu_op_e'(in_op);

   mdu_mul #(.XLEN(XLEN)) u_mul (.op(op_e), .a(in_a), .b(in_b), .result(mul_res));
   mdu_div #(.XLEN(XLEN)) u_div (.op(op_e), .a(in_a), .b(in_b), .result(div_res));

   assign comb_res = in_op[2] ? div_res : mul_res;

   generate
      if (PIPE_STAGES == 0) begin : g_comb
         assign out_valid  = in_valid;
         assign out_result = comb_res;
      end else begin : g_pipe
         logic [PIPE_STAGES-1:0] vld_q;
         logic [XLEN-1:0]        res_q [PIPE_STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= '0;
               for (int i = 0; i < PIPE_STAGES; i++) res_q[i] <= '0;
            end else begin
               vld_q[0] <= in_valid;
               res_q[0] <= comb_res;
               for (int i = 1; i < PIPE_STAGES; i++) begin
                  vld_q[i] <= vld_q[i-1];
                  res_q[i] <= res_q[i-1];
               end
            end
         end

         assign out_valid  = vld_q[PIPE_STAGES-1];
         assign out_result = res_q[PIPE_STAGES-1];
      end
   endgenerate

   generate
      if (PIPE_STAGES == 1) begin : g_chk
         p_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         p_divzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (op_e == OP_DIV || op_e == OP_DIVU) && in_b == '0)
            |=> (out_result == '1));
         p_remzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (op_e == OP_REM || op_e == OP_REMU) && in_b == '0)
            |=> (out_result == $past(in_a)));
         p_ovf_div_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_e == OP_DIV && in_a == {1'b1, {(XLEN-1){1'b0}}} && in_b == '1)
            |=> (out_result == $past(in_a)));
         p_ovf_rem_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_e == OP_REM && in_a == {1'b1, {(XLEN-1){1'b0}}} && in_b == '1)
            |=> (out_result == '0));
      end
   endgenerate
endmodule

// File: tb/mdu_exec_tb.sv
module mdu_exec_tb;
   localparam int XLEN = 32;
   localparam int NV   = 25;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [2:0]      in_op = '0;
   logic [XLEN-1:0] in_a = '0, in_b = '0;
   logic            out_valid;
   logic [XLEN-1:0] out_result;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   mdu_exec #(.XLEN(XLEN), .PIPE_STAGES(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result));

   // {op, a, b, expected, requirement number}
   localparam logic [102:0] VEC [NV] = '{
      {3'd0, 32'h00000007, 32'h00000006, 32'h0000002A, 4'd1},  // R1
      {3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 4'd1},  // R1
      {3'd0, 32'h12345678, 32'h00000010, 32'h23456780, 4'd1},  // R1
      {3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 4'd2},  // R2
      {3'd1, 32'h80000000, 32'h80000000, 32'h40000000, 4'd2},  // R2
      {3'd1, 32'hFFFFFFFE, 32'h00000003, 32'hFFFFFFFF, 4'd2},  // R2
      {3'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'd3},  // R3
      {3'd2, 32'h00000002, 32'h80000000, 32'h00000001, 4'd3},  // R3
      {3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 4'd4},  // R4
      {3'd3, 32'h80000000, 32'h00000002, 32'h00000001, 4'd4},  // R4
      {3'd4, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFD, 4'd5},  // R5
      {3'd4, 32'h00000007, 32'hFFFFFFFE, 32'hFFFFFFFD, 4'd5},  // R5
      {3'd4, 32'h00000014, 32'h00000003, 32'h00000006, 4'd5},  // R5
      {3'd5, 32'hFFFFFFFE, 32'h00000002, 32'h7FFFFFFF, 4'd6},  // R6
      {3'd5, 32'h00000064, 32'h00000007, 32'h0000000E, 4'd6},  // R6
      {3'd6, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 4'd7},  // R7
      {3'd6, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 4'd7},  // R7
      {3'd7, 32'hFFFFFFFF, 32'h0000000A, 32'h00000005, 4'd8},  // R8
      {3'd7, 32'h00000064, 32'h00000007, 32'h00000002, 4'd8},  // R8
      {3'd4, 32'h00000005, 32'h00000000, 32'hFFFFFFFF, 4'd9},  // R9
      {3'd5, 32'h00001234, 32'h00000000, 32'hFFFFFFFF, 4'd9},  // R9
      {3'd6, 32'hFFFFFFF9, 32'h00000000, 32'hFFFFFFF9, 4'd10}, // R10
      {3'd7, 32'h00001234, 32'h00000000, 32'h00001234, 4'd10}, // R10
      {3'd4, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 4'd11}, // R11
      {3'd6, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 4'd11}  // R11
   };

   task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      // R12: reset state
      #5;
      check("R12", {31'd0, out_valid}, 32'd0);
      check("R12", out_result, 32'd0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #5;
      check("R12", {31'd0, out_valid}, 32'd0);

      // table walk, back-to-back issue
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_op    = VEC[i][102:100];
         in_a     = VEC[i][99:68];
         in_b     = VEC[i][67:36];
         @(posedge clk); #5;
         check($sformatf("R%0d", VEC[i][3:0]), out_result, VEC[i][35:4]);
         check("R12", {31'd0, out_valid}, 32'd1);
      end

      // R12: single pulse does not linger
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #5;
      check("R12", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      in_valid = 1'b1; in_op = 3'd3; in_a = 32'h00010000; in_b = 32'h00010000;
      @(posedge clk); #5;
      check("R12", {31'd0, out_valid}, 32'd1);
      check("R4", out_result, 32'h00000001);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #5;
      check("R12", {31'd0, out_valid}, 32'd0);

      // R12: reset while busy clears output
      @(negedge clk);
      in_valid = 1'b1; in_op = 3'd0; in_a = 32'd3; in_b = 32'd5;
      @(posedge clk); #5;
      check("R1", out_result, 32'd15);
      rst_n = 1'b0;
      #1;
      check("R12", {31'd0, out_valid}, 32'd0);
      check("R12", out_result, 32'd0);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule